// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN protocol controller may leave the bus-off state. A single-cycle entry pulse starts a recovery period. From then on the block watches the sampled bus level on every bit tick. It counts runs of consecutive recessive bits, and it counts how many complete runs have been seen. Automatic recovery finishes once the required number of runs has been observed. The block then issues a one-cycle rejoin pulse, and the surrounding controller goes back onto the bus.

Software can hold off recovery with a hold input. The block captures this input when bus off begins. During a bus-off period the captured copy can only be released, never set again. The effect of a release depends on timing. A release before the run target is reached lets recovery continue as if no hold had been requested. A release after the target has been reached makes the block wait for one more full recessive run, so that it resynchronises with the bus before rejoining.

Top module: `busoff_recovery`

## Requirements
- R1: After reset, bus_off_o, rejoin_o and hold_active_o are all 0.
- R2: A high busoff_enter_i sampled at a clock edge makes bus_off_o 1 after that edge, copies hold_i into hold_active_o, and clears both counters. This also applies when the block is already in bus off, so counting restarts from zero.
- R3: Bits are taken only on edges where bit_tick_i is 1. bit_val_i = 1 means recessive and 0 means dominant. A dominant bit restarts the run. RUN_LEN (11) consecutive recessive bits make one sequence, and the run then starts again from zero.
- R4: If hold_active_o is 0, rejoin_o goes high after the edge that samples the last recessive bit of sequence SEQ_TARGET (128). bus_off_o goes low after that same edge.
- R5: While hold_active_o is 1 and hold_i stays 1, no rejoin occurs, no matter how many sequences pass.
- R6: If hold_i is cleared while the sequence count is below SEQ_TARGET, hold_active_o drops and rejoin occurs at sequence SEQ_TARGET, exactly as in R4.
- R7: If hold_i is cleared after SEQ_TARGET sequences have been seen, hold_active_o drops, the run count restarts (a tick on the release edge is discarded), and rejoin follows the next complete run of RUN_LEN recessive bits.
- R8: If hold_i is 0 at entry, setting hold_i during that bus-off period leaves hold_active_o at 0 and does not change when rejoin occurs.
- R9: Setting hold_i again after a release during the same bus-off period is ignored. hold_active_o stays 0 and rejoin is not delayed.
- R10: rejoin_o is a single-cycle pulse. After it, all counts are cleared, so the next bus-off period needs the full SEQ_TARGET sequences again.
- R11: While bus_off_o is 0, bit ticks are ignored and rejoin_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busoff_enter_i | input | 1 | Single-cycle pulse that starts bus off |
| hold_i | input | 1 | Software request to hold off automatic recovery |
| bit_tick_i | input | 1 | Marks the cycle that carries a sampled bus bit |
| bit_val_i | input | 1 | Sampled bus level: 1 is recessive, 0 is dominant |
| bus_off_o | output | 1 | High while in bus off |
| rejoin_o | output | 1 | One-cycle pulse that allows the controller to rejoin the bus |
| hold_active_o | output | 1 | Latched hold policy for the current bus-off period |

## Verification
Every output is registered. Each output therefore reflects the inputs sampled at a clock edge from that edge onward: one clock edge after the entry pulse, after the tick that completes the final run, or after the hold release. The bench drives its inputs on falling edges. A behavioural model updates on the same rising edge as the design. Outputs are compared with the model on every falling edge, half a cycle after the edge that produced them. The directed checks also sample on the falling edge that directly follows the bit that completes a run.

// File: rtl/busoff_pkg.sv
package busoff_pkg;
  parameter int unsigned BO_RUN_LEN    = 11;
  parameter int unsigned BO_SEQ_TARGET = 128;
endpackage

// File: rtl/busoff_run_cnt.sv
module busoff_run_cnt #(
  parameter int unsigned RUN_LEN = busoff_pkg::BO_RUN_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic rec_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = tick_i & rec_i & (cnt_q == LAST) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i) begin
      if (!rec_i || hit_o)      cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_run_below_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(RUN_LEN));
  a_r3_dominant_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !rec_i |=> cnt_q == '0);
endmodule

// File: rtl/busoff_seq_cnt.sv
module busoff_seq_cnt #(
  parameter int unsigned SEQ_TARGET = busoff_pkg::BO_SEQ_TARGET
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o,
  output logic last_o
);
  localparam int unsigned SW = $clog2(SEQ_TARGET + 1);
  localparam logic [SW-1:0] TGT = SW'(SEQ_TARGET);

  logic [SW-1:0] cnt_q;

  assign done_o = (cnt_q == TGT);
  assign last_o = inc_i & (cnt_q == TGT - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r4_seq_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TGT);
  a_r10_seq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/busoff_policy.sv
module busoff_policy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_i,
  input  logic hold_i,
  input  logic bus_off_i,
  input  logic seq_done_i,
  input  logic rejoin_i,
  output logic hold_lat_o,
  output logic resync_o,
  output logic late_rel_o
);
  logic hold_q, resync_q, release_c;

  assign release_c  = bus_off_i & hold_q & ~hold_i & ~entry_i;
  assign late_rel_o = release_c & seq_done_i;
  assign hold_lat_o = hold_q;
  assign resync_o   = resync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      resync_q <= 1'b0;
    end else if (entry_i) begin
      hold_q   <= hold_i;
      resync_q <= 1'b0;
    end else if (rejoin_i) begin
      hold_q   <= 1'b0;
      resync_q <= 1'b0;
    end else if (release_c) begin
      hold_q   <= 1'b0;
      resync_q <= seq_done_i;
    end
  end

  // latched hold may only be set by an entry pulse (R8, R9)
  a_r8_hold_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_i && !hold_q |=> !hold_q);
  a_r7_resync_needs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_i && !resync_q && !(hold_q && !hold_i) |=> !resync_q);
endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery #(
  parameter int unsigned RUN_LEN    = busoff_pkg::BO_RUN_LEN,
  parameter int unsigned SEQ_TARGET = busoff_pkg::BO_SEQ_TARGET
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busoff_enter_i,
  input  logic hold_i,
  input  logic bit_tick_i,
  input  logic bit_val_i,
  output logic bus_off_o,
  output logic rejoin_o,
  output logic hold_active_o
);
  logic bus_off_q, rejoin_q;
  logic run_hit, run_clr, seq_clr, seq_done, seq_last;
  logic hold_lat, resync, late_rel, rejoin_fire, tick_act;

  assign tick_act = bit_tick_i & bus_off_q & ~busoff_enter_i;
  assign run_clr  = busoff_enter_i | rejoin_fire | late_rel | ~bus_off_q;
  assign seq_clr  = busoff_enter_i | rejoin_fire;

  busoff_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (busoff_enter_i | late_rel | ~bus_off_q),
    .tick_i (tick_act),
    .rec_i  (bit_val_i),
    .hit_o  (run_hit)
  );

  busoff_seq_cnt #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (seq_clr),
    .inc_i  (run_hit),
    .done_o (seq_done),
    .last_o (seq_last)
  );

  busoff_policy u_pol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (busoff_enter_i),
    .hold_i     (hold_i),
    .bus_off_i  (bus_off_q),
    .seq_done_i (seq_done),
    .rejoin_i   (rejoin_fire),
    .hold_lat_o (hold_lat),
    .resync_o   (resync),
    .late_rel_o (late_rel)
  );

  // effective hold: a release in this cycle already counts
  always_comb begin
    rejoin_fire = 1'b0;
    if (bus_off_q && !busoff_enter_i) begin
      if (seq_last && !(hold_lat && hold_i)) rejoin_fire = 1'b1;
      else if (seq_done && resync && run_hit) rejoin_fire = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_off_q <= 1'b0;
      rejoin_q  <= 1'b0;
    end else begin
      rejoin_q <= rejoin_fire;
      if (busoff_enter_i)   bus_off_q <= 1'b1;
      else if (rejoin_fire) bus_off_q <= 1'b0;
    end
  end

  assign bus_off_o     = bus_off_q;
  assign rejoin_o      = rejoin_q;
  assign hold_active_o = hold_lat;

  a_r10_rejoin_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejoin_q |=> !rejoin_q);
  a_r5_held_no_rejoin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_lat && hold_i |=> !rejoin_q);
  a_r11_idle_no_rejoin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_off_q |=> !rejoin_q);
  a_r4_rejoin_after_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejoin_fire |-> (seq_done || seq_last) && run_hit);
endmodule

// File: tb/busoff_recovery_tb.sv
`timescale 1ns/1ps
module busoff_recovery_tb;
  localparam int L = 11;
  localparam int T = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic entry = 1'b0, hold = 1'b0, tick = 1'b0, val = 1'b0;
  logic bus_off, rejoin, hold_act;

  int tests = 0, fails = 0, rj_cnt = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference state
  int m_run = 0, m_seq = 0;
  bit m_off = 0, m_hold = 0, m_resync = 0, m_rj = 0;

  always #2.5 clk = ~clk;

  busoff_recovery u_dut (
    .clk_i(clk), .rst_ni(rst_n), .busoff_enter_i(entry), .hold_i(hold),
    .bit_tick_i(tick), .bit_val_i(val), .bus_off_o(bus_off),
    .rejoin_o(rejoin), .hold_active_o(hold_act)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_seq = 0; m_off = 0; m_hold = 0; m_resync = 0; m_rj = 0;
    end else begin
      bit skip;
      m_rj = 0;
      skip = 0;
      if (entry) begin
        m_off = 1; m_hold = hold; m_resync = 0; m_run = 0; m_seq = 0;
      end else if (m_off) begin
        if (m_hold && !hold) begin
          m_hold = 0;
          if (m_seq >= T) begin m_resync = 1; m_run = 0; skip = 1; end
        end
        if (!skip && tick) begin
          if (val) begin
            m_run++;
            if (m_run == L) begin
              m_run = 0;
              if (m_seq < T) begin
                m_seq++;
                if (m_seq == T && !m_hold) m_rj = 1;
              end else if (m_resync) m_rj = 1;
            end
          end else m_run = 0;
        end
        if (m_rj) begin
          m_off = 0; m_hold = 0; m_resync = 0; m_run = 0; m_seq = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rejoin) rj_cnt++;
      tests++;
      if (bus_off !== m_off || rejoin !== m_rj || hold_act !== (m_hold & m_off)) begin
        fails++;
        $display("FAIL %s cycle compare: act off=%b rj=%b hold=%b exp off=%b rj=%b hold=%b",
                 cur_req, bus_off, rejoin, hold_act, m_off, m_rj, m_hold & m_off);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic bits(input int n, input int dom_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      val  = (dom_every > 0 && (i % dom_every) == dom_every - 1) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b0; entry = 1'b0;
    end
  endtask

  task automatic enter(input logic h);
    @(negedge clk);
    tick = 1'b0; entry = 1'b1; hold = h;
    @(negedge clk);
    entry = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    #12 rst_n = 1'b1;
    idle(1);
    cur_req = "R1";
    check("R1", bus_off, 1'b0, "bus_off after reset");
    check("R1", rejoin, 1'b0, "rejoin after reset");
    check("R1", hold_act, 1'b0, "hold_active after reset");

    cur_req = "R11";
    base = rj_cnt;
    bits(2000, 0); idle(2);
    check("R11", bus_off, 1'b0, "idle ticks leave bus_off");
    check_int("R11", rj_cnt - base, 0, "rejoins while idle");

    cur_req = "R3";
    enter(1'b0);
    check("R2", bus_off, 1'b1, "bus_off after entry");
    check("R2", hold_act, 1'b0, "hold latched clear");
    base = rj_cnt;
    bits(3000, 10); idle(2);
    check_int("R3", rj_cnt - base, 0, "dominant every 10th bit blocks runs");
    cur_req = "R4";
    bits(T * L - 1, 0); idle(1);
    check("R4", rejoin, 1'b0, "no rejoin one bit early");
    bits(1, 0); idle(1);
    check("R4", rejoin, 1'b1, "rejoin after final run");
    check("R4", bus_off, 1'b0, "bus_off cleared with rejoin");
    idle(1);
    check("R10", rejoin, 1'b0, "rejoin single cycle");

    cur_req = "R5";
    enter(1'b1);
    check("R2", hold_act, 1'b1, "hold latched set");
    base = rj_cnt;
    bits(T * L + 30, 0); idle(2);
    check_int("R5", rj_cnt - base, 0, "held past target");
    check("R5", bus_off, 1'b1, "still bus off while held");
    cur_req = "R7";
    @(negedge clk); hold = 1'b0;
    @(negedge clk); hold = 1'b1;
    idle(1);
    check("R9", hold_act, 1'b0, "re-set after release ignored");
    bits(L - 1, 0); idle(1);
    check_int("R7", rj_cnt - base, 0, "no rejoin before resync run");
    bits(1, 0); idle(1);
    check("R7", rejoin, 1'b1, "rejoin after one resync run");

    cur_req = "R6";
    enter(1'b1);
    bits(50 * L, 0);
    @(negedge clk); tick = 1'b0; hold = 1'b0;
    idle(1);
    check("R6", hold_act, 1'b0, "early release drops hold");
    base = rj_cnt;
    bits((T - 50) * L - 1, 0); idle(1);
    check_int("R6", rj_cnt - base, 0, "no rejoin before target");
    bits(1, 0); idle(1);
    check("R6", rejoin, 1'b1, "rejoin at target after early release");

    cur_req = "R8";
    enter(1'b0);
    bits(100, 0);
    @(negedge clk); tick = 1'b0; hold = 1'b1;
    idle(1);
    check("R8", hold_act, 1'b0, "hold set during bus off ignored");
    bits(T * L - 101, 0); idle(1);
    bits(1, 0); idle(1);
    check("R8", rejoin, 1'b1, "rejoin timing unchanged");
    hold = 1'b0;

    cur_req = "R2";
    enter(1'b0);
    bits(1000, 0);
    enter(1'b0);
    base = rj_cnt;
    bits(T * L - 1, 0); idle(1);
    check_int("R2", rj_cnt - base, 0, "re-entry restarts count");
    bits(1, 0); idle(1);
    check("R10", rejoin, 1'b1, "full count needed after restart");
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule